// File: doc/BRIEF.md
# Frame Alignment Bit Slider

This block generates a local frame pulse, one frame every `FRAME_LEN` cycles of a fast clock (8192 cycles of 65.536 MHz, or 125 µs, by default). It lines that pulse up with an incoming reference frame pulse. The clock is taken to be frequency-locked to the reference already, so only the phase of the local frame can differ. Each time a reference pulse arrives, the block reads its own frame counter and treats that value as the phase error. The error counts as inside the alignment window when the counter reads 0, 1 or `FRAME_LEN-1`.

Three alignment policies are available.

- **Slide:** every misaligned measurement shortens the next local frame by exactly one cycle. The counter value 1 is skipped right after the frame pulse. The local frame therefore walks toward the reference by one cycle per frame until it falls inside the window. The walk can take almost `FRAME_LEN` frames, and there is no timeout.
- **Snap:** the counter restarts at the reference boundary at once.
- **Free:** the local frame keeps its nominal length and is never corrected.

The clock itself is never altered; only the frame length changes. A typical use is keeping a local timing domain in step with a backplane frame when the source changes, without a sudden jump.

Top module: `frame_bit_slider`

## Requirements
- R1: While `rst` is high at a clock edge, the counter is cleared to 0 and `fp_o`, `aligned_o` and `slide_act_o` read 0 after that edge.
- R2: With no correction pending, `cnt_o` counts 0 up to `FRAME_LEN-1` and wraps to 0. `fp_o` is high for exactly the one cycle in which the counter has just wrapped to 0, so pulses are `FRAME_LEN` cycles apart.
- R3: At each clock edge where `ref_fp_i` is high, the counter value at that edge is the measured error. One cycle later `aligned_o` reads 1 if the value was 0, 1 or `FRAME_LEN-1`, and 0 for any other value. It holds that value until the next reference pulse.
- R4: In slide mode (`mode_i` = 2'b10) with `align_en_i` = 1, a measurement outside the window sets `slide_act_o` to 1 one cycle later. The next local frame then lasts `FRAME_LEN-1` cycles: the counter steps from 0 straight to 2.
- R5: In slide mode, each reference pulse that measures an error outside the window removes one more cycle. The first measurement inside the window clears `slide_act_o` and sets `aligned_o`, and no further frames are shortened.
- R6: In snap mode (`mode_i` = 2'b01) with `align_en_i` = 1, a measurement outside the window makes the counter read 1 in the next cycle, so that the reference edge becomes count 0. That frame gets no pulse, and the next measurement one frame later reads 0.
- R7: In free mode (`mode_i` = 2'b00, and also 2'b11), reference pulses change no counter value and no frame length, and `slide_act_o` reads 0 afterwards.
- R8: With `align_en_i` = 0, no mode corrects the counter, and a reference pulse leaves `slide_act_o` at 0.
- R9: If reference pulses stop after a slide decision, exactly one frame is shortened. Later frames keep the nominal `FRAME_LEN` length.
- R10: `mode_i` and `align_en_i` are used only at reference pulses. A shortening decided in slide mode is still carried out if the mode changes before the frame wraps. The new mode governs from the next reference pulse on.
- R11: Starting from an error of 2, which is the largest in slide mode, alignment completes after exactly `FRAME_LEN-3` shortened frames, with no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast frame clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_fp_i | input | 1 | Reference frame pulse, one cycle wide |
| mode_i | input | 2 | Alignment policy: 00 free, 01 snap, 10 slide, 11 free |
| align_en_i | input | 1 | Enables any correction |
| fp_o | output | 1 | Generated frame pulse, one cycle wide |
| cnt_o | output | $clog2(FRAME_LEN) | Local frame cycle counter |
| aligned_o | output | 1 | Last measured error was inside the window |
| slide_act_o | output | 1 | Slide in progress |

## Verification
Every result takes one register stage. A reference pulse sampled at edge N updates `aligned_o`, `slide_act_o` and, in snap mode, `cnt_o` after edge N. A slide decision shows up only at the following counter wrap, as a pulse spacing of `FRAME_LEN-1`.

The bench drives inputs and samples outputs on the falling edge. It keeps a cycle-by-cycle expected model, updated on the rising edge, and compares against it on every falling edge. Directed checks read the flags at the falling edge just after the reference pulse, and they count shortened frames from the spacing of `fp_o` pulses. The bench uses `FRAME_LEN` = 64, so the longest slide finishes within a few thousand cycles.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    ALN_FREE  = 2'b00,
    ALN_SNAP  = 2'b01,
    ALN_SLIDE = 2'b10,
    ALN_FREE2 = 2'b11
  } aln_mode_e;

  // True when the counter value sampled at a reference pulse is
  // within one cycle of the frame boundary.
  function automatic logic phase_in_window(input int unsigned c,
                                           input int unsigned len);
    return (c == 0) || (c == 1) || (c == len - 1);
  endfunction

  // Next counter value: snap load wins, then wrap, then skip of count 1.
  function automatic int unsigned count_next(input int unsigned c,
                                             input int unsigned len,
                                             input logic        load_one,
                                             input logic        skip_one);
    if (load_one)                return 1;
    else if (c == len - 1)       return 0;
    else if (skip_one && c == 0) return 2;
    else                         return c + 1;
  endfunction

endpackage

// File: rtl/fbs_frame_ctr.sv
module fbs_frame_ctr #(
  parameter int LEN = 8192,
  parameter int CW  = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_one,
  input  logic          skip_req,
  output logic [CW-1:0] cnt,
  output logic          fp,
  output logic          skip_taken
);
  import fbs_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_nxt;

  assign skip_taken = skip_req && (cnt == '0) && !load_one;
  assign cnt_nxt    = CW'(count_next(32'(cnt), 32'(LEN), load_one, skip_taken));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      fp  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      fp  <= !load_one && (cnt == LAST);
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  p_fp_width_r2: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp);

  p_jump_two_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(2)) |-> ($past(cnt) == CW'(1) || $past(cnt) == '0));

  p_snap_one_r6: assert property (@(posedge clk) disable iff (rst)
    load_one |=> (cnt == CW'(1)));

endmodule

// File: rtl/fbs_phase_meas.sv
module fbs_phase_meas #(
  parameter int LEN = 8192,
  parameter int CW  = $clog2(LEN)
) (
  input  logic [CW-1:0] cnt,
  input  logic          ref_fp,
  output logic          meas_evt,
  output logic          in_win
);
  import fbs_pkg::*;

  assign meas_evt = ref_fp;
  assign in_win   = phase_in_window(32'(cnt), 32'(LEN));

endmodule

// File: rtl/fbs_align_ctrl.sv
module fbs_align_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       meas_evt,
  input  logic       in_win,
  input  logic [1:0] mode,
  input  logic       en,
  input  logic       skip_taken,
  output logic       snap_req,
  output logic       skip_req,
  output logic       aligned,
  output logic       slide_act
);
  import fbs_pkg::*;

  logic pend;
  logic slide_dec;

  assign slide_dec = meas_evt && en && (mode == ALN_SLIDE) && !in_win;
  assign snap_req  = meas_evt && en && (mode == ALN_SNAP)  && !in_win;
  assign skip_req  = pend && !meas_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      aligned   <= 1'b0;
      slide_act <= 1'b0;
    end else if (meas_evt) begin
      aligned   <= in_win;
      slide_act <= slide_dec;
      pend      <= slide_dec;
    end else if (skip_taken) begin
      pend      <= 1'b0;
    end
  end

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(slide_act && aligned));

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (meas_evt && !en) |=> !slide_act);

  p_skip_needs_pend_r10: assert property (@(posedge clk) disable iff (rst)
    skip_taken |-> pend);

endmodule

// File: rtl/frame_bit_slider.sv
module frame_bit_slider #(
  parameter  int FRAME_LEN = 8192,
  localparam int CW        = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_fp_i,
  input  logic [1:0]    mode_i,
  input  logic          align_en_i,
  output logic          fp_o,
  output logic [CW-1:0] cnt_o,
  output logic          aligned_o,
  output logic          slide_act_o
);

  logic snap_req;
  logic skip_req;
  logic skip_taken;
  logic meas_evt;
  logic in_win;

  fbs_frame_ctr #(.LEN(FRAME_LEN), .CW(CW)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_one   (snap_req),
    .skip_req   (skip_req),
    .cnt        (cnt_o),
    .fp         (fp_o),
    .skip_taken (skip_taken)
  );

  fbs_phase_meas #(.LEN(FRAME_LEN), .CW(CW)) u_meas (
    .cnt      (cnt_o),
    .ref_fp   (ref_fp_i),
    .meas_evt (meas_evt),
    .in_win   (in_win)
  );

  fbs_align_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .meas_evt   (meas_evt),
    .in_win     (in_win),
    .mode       (mode_i),
    .en         (align_en_i),
    .skip_taken (skip_taken),
    .snap_req   (snap_req),
    .skip_req   (skip_req),
    .aligned    (aligned_o),
    .slide_act  (slide_act_o)
  );

  p_fp_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
    fp_o |-> (cnt_o == '0));

endmodule

// File: tb/frame_bit_slider_bench.sv
module frame_bit_slider_bench;

  localparam int L  = 64;
  localparam int CW = $clog2(L);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_fp = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          en = 1'b1;
  logic          fp;
  logic [CW-1:0] cnt;
  logic          aligned;
  logic          slide_act;

  always #2.5 clk = ~clk;

  frame_bit_slider #(.FRAME_LEN(L)) u_frame_bit_slider (
    .clk         (clk),
    .rst         (rst),
    .ref_fp_i    (ref_fp),
    .mode_i      (mode),
    .align_en_i  (en),
    .fp_o        (fp),
    .cnt_o       (cnt),
    .aligned_o   (aligned),
    .slide_act_o (slide_act)
  );

  int checks = 0, errors = 0;
  int m_checks = 0, m_errors = 0;
  int wd_errors = 0;

  // ---------------- expected model, advanced on rising edges ---------
  int  e_cnt = 0;
  bit  e_fp = 0, e_al = 0, e_sa = 0, e_pend = 0, started = 0;

  function automatic bit win(int c);
    return (c <= 1) || (c == L - 1);
  endfunction

  always @(posedge clk) begin
    bit w, snap, skip, sd;
    int nx;
    started = 1;
    if (rst) begin
      e_cnt = 0; e_fp = 0; e_al = 0; e_sa = 0; e_pend = 0;
    end else begin
      w    = win(e_cnt);
      sd   = ref_fp && en && mode == 2'b10 && !w;
      snap = ref_fp && en && mode == 2'b01 && !w;
      skip = e_pend && !ref_fp && e_cnt == 0;
      if (snap)               nx = 1;
      else if (e_cnt == L-1)  nx = 0;
      else if (skip)          nx = 2;
      else                    nx = e_cnt + 1;
      e_fp = !snap && (e_cnt == L - 1);
      if (ref_fp) begin
        e_al = w; e_sa = sd; e_pend = sd;
      end else if (skip) begin
        e_pend = 0;
      end
      e_cnt = nx;
    end
  end

  // ---------------- per-cycle compare and pulse spacing monitor ------
  int cyc = 0, last_fp = -1, last_len = 0, n_short = 0, n_fp = 0;

  always @(negedge clk) begin
    cyc++;
    if (started) begin
      m_checks += 3;
      if (int'(cnt) != e_cnt || fp != e_fp) begin
        m_errors++;
        $display("FAIL R2 cyc %0d: cnt=%0d fp=%0b expected cnt=%0d fp=%0b",
                 cyc, cnt, fp, e_cnt, e_fp);
      end
      if (aligned != e_al) begin
        m_errors++;
        $display("FAIL R3 cyc %0d: aligned=%0b expected %0b", cyc, aligned, e_al);
      end
      if (slide_act != e_sa) begin
        m_errors++;
        $display("FAIL R4 cyc %0d: slide_act=%0b expected %0b", cyc, slide_act, e_sa);
      end
    end
    if (fp && !rst) begin
      if (last_fp >= 0) begin
        last_len = cyc - last_fp;
        if (last_len == L - 1) n_short++;
      end
      last_fp = cyc;
      n_fp++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse the reference for the edge at which the counter reads k.
  task automatic ref_at(input int k);
    int guard = 0;
    @(negedge clk);
    while (int'(cnt) != k && guard < 3 * L) begin
      @(negedge clk);
      guard++;
    end
    ref_fp = 1'b1;
    @(negedge clk);
    ref_fp = 1'b0;
  endtask

  // Periodic reference train, first pulse at counter value k.
  task automatic ref_train(input int k, input int frames);
    ref_at(k);
    for (int f = 1; f < frames; f++) begin
      cycles(L - 1);
      ref_fp = 1'b1;
      @(negedge clk);
      ref_fp = 1'b0;
    end
  endtask

  task automatic finish_run();
    int te, tc;
    te = errors + m_errors + wd_errors;
    tc = checks + m_checks + wd_errors;
    $display("Result: errors=%0d of %0d checks", te, tc);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int base, k;
    process::self().srandom(32'd1234);
    cycles(3);
    // R1 reset state
    chk(cnt == 0 && fp == 0 && aligned == 0 && slide_act == 0, "R1 reset",
        {cnt, fp, aligned, slide_act}, 0);
    rst = 1'b0;

    // R2 free running spacing
    mode = 2'b10; en = 1'b1;
    cycles(3 * L);
    chk(last_len == L, "R2 nominal spacing", last_len, L);
    chk(n_short == 0, "R2 no short frames", n_short, 0);

    // R4 slide decision, R9 only one short frame with reference gone
    ref_at(10);
    chk(slide_act == 1, "R4 slide_act after error 10", slide_act, 1);
    chk(aligned == 0, "R3 error 10 not aligned", aligned, 0);
    base = n_short;
    cycles(3 * L);
    chk(n_short - base == 1, "R4 one frame shortened", n_short - base, 1);
    chk(last_len == L, "R9 nominal after missing reference", last_len, L);

    // R5/R11 full walk from largest error
    base = n_short;
    ref_train(2, 2 * L);
    chk(n_short - base == L - 3, "R11 shortened frame count", n_short - base, L - 3);
    chk(aligned == 1, "R5 aligned at end", aligned, 1);
    chk(slide_act == 0, "R5 slide stopped", slide_act, 0);
    base = n_short;
    cycles(2 * L);
    chk(n_short == base, "R5 no more shortening", n_short - base, 0);

    // R6 snap
    mode = 2'b01;
    ref_at(20);
    chk(cnt == 1, "R6 snap loads one", cnt, 1);
    chk(slide_act == 0, "R6 no slide in snap", slide_act, 0);
    ref_at(0);
    chk(aligned == 1, "R3 error 0 aligned after snap", aligned, 1);

    // R3 edge values, R7 free modes
    mode = 2'b00;
    ref_at(L - 1);
    chk(aligned == 1, "R3 error L-1 aligned", aligned, 1);
    ref_at(5);
    chk(aligned == 0, "R3 error 5 not aligned", aligned, 0);
    ref_at(20);
    chk(cnt == 21, "R7 free mode 00 untouched", cnt, 21);
    mode = 2'b11;
    ref_at(30);
    chk(cnt == 31 && slide_act == 0, "R7 free mode 11 untouched", cnt, 31);

    // R8 disabled
    en = 1'b0; mode = 2'b10;
    ref_at(20);
    chk(slide_act == 0, "R8 no slide when disabled", slide_act, 0);
    base = n_short;
    cycles(2 * L);
    chk(n_short == base, "R8 no shortening when disabled", n_short - base, 0);
    mode = 2'b01;
    ref_at(20);
    chk(cnt == 21, "R8 no snap when disabled", cnt, 21);

    // R10 mode change after a slide decision
    en = 1'b1; mode = 2'b10;
    ref_at(40);
    mode = 2'b00;
    base = n_short;
    cycles(2 * L);
    chk(n_short - base == 1, "R10 decided shortening still applied", n_short - base, 1);
    ref_at(40);
    chk(slide_act == 0, "R10 new mode at next event", slide_act, 0);

    // random phases and modes, checked by the model every cycle
    for (int i = 0; i < 60; i++) begin
      mode = 2'($urandom_range(0, 3));
      en   = ($urandom_range(0, 7) != 0);
      k    = $urandom_range(2, L - 1);
      if ($urandom_range(0, 3) == 0) cycles($urandom_range(1, 2 * L));
      else ref_train(k, $urandom_range(1, 4));
    end
    cycles(4);
    finish_run();
  end

endmodule